// File: doc/BRIEF.md
# Bit-Manipulation and Shift Execution Unit

This unit executes the second opcode byte of an 8-bit processor's bit-manipulation prefix group. It also executes the four single-byte accumulator rotates. Each valid request supplies four things: the opcode byte, a flag telling whether that byte followed the prefix, the operand value already fetched by the surrounding datapath, and the current flag byte. One clock later the unit returns four things: the result byte, a write enable, the operand selector naming where the result goes, and the new flag byte.

A prefixed opcode is decoded by its fixed field layout. The two top bits pick the operation group. For shift groups, the middle three bits pick the shift kind. For bit groups, the same three bits pick the bit index. The low three bits name the operand. The unit does not fetch operands, sequence prefixes or form indexed addresses. Those stay with the caller, which uses the selector output to route the write-back.

Top module: `bit_shift_unit`

## Requirements
- R1: Outputs are registered. `out_valid` is high exactly in the cycle after `in_valid` was high, and `wr_en` is never high while `out_valid` is low.
- R2: For a prefixed opcode with bits 7:6 = 00, bits 5:3 choose the shift. The codes are:
  - 0: circular left, where the old bit 7 goes into bit 0.
  - 1: circular right, where the old bit 0 goes into bit 7.
  - 2: left through carry, where the incoming carry enters bit 0.
  - 3: right through carry, where the incoming carry enters bit 7.
  - 4: arithmetic left, inserting 0.
  - 5: arithmetic right, keeping bit 7.
  - 6: logical left, inserting 1.
  - 7: logical right, inserting 0.

  In every case the bit shifted out goes to carry, and `wr_en` is 1.
- R3: Flag byte positions are S=7, Z=6, H=4, P=2, N=1, C=0. For prefixed shifts:
  - S is result bit 7.
  - Z is 1 when the result is zero.
  - H and N are 0.
  - P is 1 when the result has an even number of ones.
  - C is the shifted-out bit.
  - Bits 5 and 3 pass through from `flags_in`.
- R4: For a prefixed opcode with bits 7:6 = 01 (bit test of bit index opcode[5:3]):
  - Z is the inverse of the tested bit.
  - H is 1 and N is 0.
  - All other flag bits, including C, are unchanged.
  - `wr_en` is 0 and `result` equals the operand.
- R5: For a prefixed opcode with bits 7:6 = 10 or 11, the operand bit opcode[5:3] is cleared (10) or set (11), `wr_en` is 1, and the flags equal `flags_in`.
- R6: For an unprefixed opcode 0x07, 0x0F, 0x17 or 0x1F, the operand is rotated like prefixed codes 0, 1, 2 and 3 respectively, and `wr_en` is 1. H and N are 0, C is the shifted-out bit, and S, Z, P and bits 5 and 3 are unchanged.
- R7: Any other unprefixed opcode gives `wr_en` = 0, `result` equal to the operand, and flags equal to `flags_in`.
- R8: While `rst_n` is low, every output is 0.
- R9: `dest_sel` equals opcode[2:0]. The selector encoding is B=0, C=1, D=2, E=3, H=4, L=5, memory=6, A=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| prefixed | input | 1 | 1: opcode is the byte after the bit prefix; 0: single-byte opcode |
| opcode | input | 8 | Opcode byte |
| operand | input | 8 | Operand value |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Result present |
| result | output | 8 | Result byte |
| wr_en | output | 1 | Result must be written back |
| dest_sel | output | 3 | Operand selector for write-back |
| flags_out | output | 8 | New flag byte |

## Verification
A wrong decode shows up at the ports one cycle after the request, in several ways:
- a flipped bit or an inserted bit of the wrong polarity in `result`;
- a stray write enable on a bit test;
- flag bits that should have passed through but did not.

Because the unit keeps no state beyond its single output stage, every fault is visible on the very next cycle and never later. That makes an exhaustive sweep of both opcode spaces against operand and flag patterns, compared cycle by cycle, decisive.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int DW     = 8;
  localparam int SEL_W  = 3;
  localparam int FL_S   = 7;
  localparam int FL_Z   = 6;
  localparam int FL_H   = 4;
  localparam int FL_P   = 2;
  localparam int FL_N   = 1;
  localparam int FL_C   = 0;

  typedef enum logic [2:0] {
    K_PASS  = 3'd0,
    K_SHIFT = 3'd1,
    K_TEST  = 3'd2,
    K_CLR   = 3'd3,
    K_SET   = 3'd4,
    K_ACC   = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [SEL_W-1:0]  sel;
    logic [SEL_W-1:0]  dst;
  } dec_t;

  // Returns {carry_out, result}
  function automatic logic [DW:0] shift_calc(input logic [2:0] code,
                                             input logic [DW-1:0] v,
                                             input logic cin);
    logic [DW-1:0] r;
    logic          co;
    case (code)
      3'd0: begin co = v[DW-1]; r = {v[DW-2:0], v[DW-1]}; end
      3'd1: begin co = v[0];    r = {v[0], v[DW-1:1]};    end
      3'd2: begin co = v[DW-1]; r = {v[DW-2:0], cin};     end
      3'd3: begin co = v[0];    r = {cin, v[DW-1:1]};     end
      3'd4: begin co = v[DW-1]; r = {v[DW-2:0], 1'b0};    end
      3'd5: begin co = v[0];    r = {v[DW-1], v[DW-1:1]}; end
      3'd6: begin co = v[DW-1]; r = {v[DW-2:0], 1'b1};    end
      default: begin co = v[0]; r = {1'b0, v[DW-1:1]};    end
    endcase
    return {co, r};
  endfunction

  function automatic logic even_parity(input logic [DW-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
(
  input  logic          prefixed,
  input  logic [DW-1:0] opcode,
  output dec_t          dec
);
  logic acc_rot;
  assign acc_rot = (opcode[7:5] == 3'b000) && (opcode[2:0] == 3'b111);

  always_comb begin
    dec.dst  = opcode[2:0];
    dec.sel  = opcode[5:3];
    dec.kind = K_PASS;
    if (prefixed) begin
      case (opcode[7:6])
        2'b00:   dec.kind = K_SHIFT;
        2'b01:   dec.kind = K_TEST;
        2'b10:   dec.kind = K_CLR;
        default: dec.kind = K_SET;
      endcase
    end else if (acc_rot) begin
      dec.kind = K_ACC;
      dec.sel  = {1'b0, opcode[4:3]};
    end
  end
endmodule

// File: rtl/bsu_shifter.sv
module bsu_shifter
  import bsu_pkg::*;
(
  input  logic [2:0]    code,
  input  logic [DW-1:0] val,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic [DW:0] packed_out;
  assign packed_out = shift_calc(code, val, cin);
  assign res  = packed_out[DW-1:0];
  assign cout = packed_out[DW];
endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop
  import bsu_pkg::*;
#(
  parameter int WIDTH = DW
) (
  input  logic [SEL_W-1:0] idx,
  input  logic [WIDTH-1:0] val,
  output logic [WIDTH-1:0] clr_res,
  output logic [WIDTH-1:0] set_res,
  output logic             bit_val
);
  logic [WIDTH-1:0] mask;
  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign mask[i]    = (idx == SEL_W'(i));
    assign clr_res[i] = val[i] & ~mask[i];
    assign set_res[i] = val[i] |  mask[i];
  end
  assign bit_val = |(val & mask);
endmodule

// File: rtl/bsu_flags.sv
module bsu_flags
  import bsu_pkg::*;
(
  input  kind_e         kind,
  input  logic [DW-1:0] shres,
  input  logic          cout,
  input  logic          bit_val,
  input  logic [DW-1:0] fin,
  output logic [DW-1:0] fout
);
  always_comb begin
    fout = fin;
    case (kind)
      K_SHIFT: begin
        fout[FL_S] = shres[DW-1];
        fout[FL_Z] = (shres == '0);
        fout[FL_H] = 1'b0;
        fout[FL_P] = even_parity(shres);
        fout[FL_N] = 1'b0;
        fout[FL_C] = cout;
      end
      K_ACC: begin
        fout[FL_H] = 1'b0;
        fout[FL_N] = 1'b0;
        fout[FL_C] = cout;
      end
      K_TEST: begin
        fout[FL_Z] = ~bit_val;
        fout[FL_H] = 1'b1;
        fout[FL_N] = 1'b0;
      end
      default: fout = fin;
    endcase
  end
endmodule

// File: rtl/bit_shift_unit.sv
module bit_shift_unit
  import bsu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          prefixed,
  input  logic [7:0]    opcode,
  input  logic [7:0]    operand,
  input  logic [7:0]    flags_in,
  output logic          out_valid,
  output logic [7:0]    result,
  output logic          wr_en,
  output logic [2:0]    dest_sel,
  output logic [7:0]    flags_out
);
  dec_t          dec;
  logic [DW-1:0] sh_res, clr_res, set_res, flags_nx, res_nx;
  logic          sh_cout, bit_val, wr_nx;
  kind_e         kind_q;
  logic [2:0]    sel_q;

  bsu_decode u_dec (.prefixed(prefixed), .opcode(opcode), .dec(dec));

  bsu_shifter u_sh (.code(dec.sel), .val(operand), .cin(flags_in[FL_C]),
                    .res(sh_res), .cout(sh_cout));

  bsu_bitop #(.WIDTH(DW)) u_bit (.idx(dec.sel), .val(operand),
                                 .clr_res(clr_res), .set_res(set_res),
                                 .bit_val(bit_val));

  bsu_flags u_fl (.kind(dec.kind), .shres(sh_res), .cout(sh_cout),
                  .bit_val(bit_val), .fin(flags_in), .fout(flags_nx));

  always_comb begin
    res_nx = operand;
    wr_nx  = 1'b0;
    case (dec.kind)
      K_SHIFT, K_ACC: begin res_nx = sh_res;  wr_nx = 1'b1; end
      K_CLR:          begin res_nx = clr_res; wr_nx = 1'b1; end
      K_SET:          begin res_nx = set_res; wr_nx = 1'b1; end
      default:        begin res_nx = operand; wr_nx = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      dest_sel  <= '0;
      flags_out <= '0;
      kind_q    <= K_PASS;
      sel_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_nx;
        wr_en     <= wr_nx;
        dest_sel  <= dec.dst;
        flags_out <= flags_nx;
        kind_q    <= dec.kind;
        sel_q     <= dec.sel;
      end else begin
        wr_en     <= 1'b0;
      end
    end
  end

  // R1: one-cycle latency and write enable gated by valid
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_wr_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wr_en);
  // R2: arithmetic right shift keeps the sign bit
  a_r2_sra_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.kind == K_SHIFT && dec.sel == 3'd5) |=> result[7] == $past(operand[7]));
  // R3: prefixed shifts clear H and N and report even parity
  a_r3_shift_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind_q == K_SHIFT) |->
      (!flags_out[FL_H] && !flags_out[FL_N] && flags_out[FL_P] == ~(^result)));
  // R4: bit test never writes
  a_r4_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind_q == K_TEST) |-> !wr_en && flags_out[FL_H]);
  // R5: bit clear/set keep flags
  a_r5_bitmod_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (dec.kind == K_CLR || dec.kind == K_SET)) |=> flags_out == $past(flags_in));
  // R6: accumulator rotates keep S, Z and P
  a_r6_acc_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.kind == K_ACC) |=>
      (flags_out[FL_S] == $past(flags_in[FL_S]) && flags_out[FL_Z] == $past(flags_in[FL_Z])
       && flags_out[FL_P] == $past(flags_in[FL_P]) && sel_q[2] == 1'b0));
endmodule

// File: tb/bit_shift_unit_test.sv
module bit_shift_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, prefixed = 1'b0;
  logic [7:0] opcode = '0, operand = '0, flags_in = '0;
  logic       out_valid, wr_en;
  logic [7:0] result, flags_out;
  logic [2:0] dest_sel;

  int errors = 0, checks = 0;
  bit pend = 0;
  bit exp_wr;
  int exp_res, exp_fl, exp_dst;
  string exp_tag;

  always #2.5 clk = ~clk;

  bit_shift_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prefixed(prefixed),
    .opcode(opcode), .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .dest_sel(dest_sel), .flags_out(flags_out));

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (op=%0h pf=%0b v=%0h f=%0h)",
               tag, act, expv, opcode, prefixed, operand, flags_in);
    end
  endtask

  function automatic int ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  // Behavioural model of the requirements
  task automatic model(input bit pf, input int op, input int v, input int f,
                       output bit wr, output int r, output int nf, output string tag);
    int grp = (op >> 6) & 3, sel = (op >> 3) & 7, c = 0, fc = f & 1, kind;
    bit doshift = 0;
    wr = 0; r = v; nf = f; tag = "R7";
    if (pf) begin
      if (grp == 0) begin doshift = 1; kind = sel; end
    end else if ((op & 8'hE7) == 8'h07) begin doshift = 1; kind = (op >> 3) & 3; end
    if (doshift) begin
      case (kind)
        0: begin c = v >> 7; r = ((v * 2) | c) % 256; end
        1: begin c = v % 2;  r = (v / 2) + c * 128; end
        2: begin c = v >> 7; r = ((v * 2) + fc) % 256; end
        3: begin c = v % 2;  r = (v / 2) + fc * 128; end
        4: begin c = v >> 7; r = (v * 2) % 256; end
        5: begin c = v % 2;  r = (v / 2) + (v & 128); end
        6: begin c = v >> 7; r = (v * 2 + 1) % 256; end
        default: begin c = v % 2; r = v / 2; end
      endcase
      wr = 1;
      if (pf) begin
        tag = "R2/R3";
        nf = (f & 8'h28) | (r >= 128 ? 128 : 0) | (r == 0 ? 64 : 0)
             | ((ones(r) % 2 == 0) ? 4 : 0) | c;
      end else begin
        tag = "R6";
        nf = (f & 8'hEC) | c;
      end
    end else if (pf && grp == 1) begin
      tag = "R4";
      nf = (f & ~(64 + 16 + 2)) | 16 | ((((v >> sel) & 1) == 0) ? 64 : 0);
    end else if (pf && grp == 2) begin
      tag = "R5"; wr = 1; r = v & ~(1 << sel) & 255;
    end else if (pf && grp == 3) begin
      tag = "R5"; wr = 1; r = v | (1 << sel);
    end
  endtask

  // One clock: check the previous request, then drive the next one
  task automatic step(input bit vld, input bit pf, input int op, input int v, input int f);
    @(negedge clk);
    if (pend) begin
      chk({"R1 valid ", exp_tag}, out_valid, 1);
      chk({exp_tag, " result"}, result, exp_res);
      chk({exp_tag, " wr_en"}, wr_en, exp_wr);
      chk({exp_tag, " flags"}, flags_out, exp_fl);
      chk("R9 dest_sel", dest_sel, exp_dst);
    end else begin
      chk("R1 idle valid", out_valid, 0);
      chk("R1 idle wr_en", wr_en, 0);
    end
    in_valid = vld; prefixed = pf; opcode = op[7:0]; operand = v[7:0]; flags_in = f[7:0];
    pend = vld;
    if (vld) begin
      model(pf, op, v, f, exp_wr, exp_res, exp_fl, exp_tag);
      exp_dst = op & 7;
    end
  endtask

  initial begin
    int vals[6] = '{8'h00, 8'hFF, 8'h81, 8'h5A, 8'hA5, 8'h01};
    int fls[6]  = '{8'h00, 8'hFF, 8'h01, 8'hD5, 8'h28, 8'hFE};
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 out_valid", out_valid, 0);
    chk("R8 result", result, 0);
    chk("R8 wr_en", wr_en, 0);
    chk("R8 flags", flags_out, 0);
    chk("R8 dest_sel", dest_sel, 0);
    rst_n = 1'b1;
    for (int p = 0; p < 6; p++)
      for (int pf = 0; pf < 2; pf++)
        for (int op = 0; op < 256; op++)
          step(1'b1, pf[0], op, vals[p], fls[p]);
    // gaps between requests (R1)
    for (int op = 0; op < 32; op++) begin
      step(1'b1, 1'b1, op * 8 + 3, 8'h3C, 8'h01);
      step(1'b0, 1'b0, 0, 0, 0);
    end
    step(1'b0, 1'b0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule